// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a register copy of every word of a one-time-programmable fuse array. Software reads the fuses through a window of shadow registers on a simple register bus, so the array itself is not touched. A small control register shows whether the bank is busy or has flagged an error. Through a set alias and a clear alias of that register, software can start a reload of the whole bank or clear the error flag.

A reload reads the array one word at a time through the fuse read port. For each word the read strobe is held for a set number of cycles and then released for a settle period before the word is captured into its shadow slot. At the moment of the reload request the block takes a snapshot of a per-word read-lock vector and a per-word write-lock vector. Reading a read-locked word returns a fixed poison pattern. Writing a write-locked word, or writing any shadow word while a reload runs, is refused. Each of these violations raises one sticky error flag, and the block accepts no further shadow accesses or reloads until software clears that flag. A reload also waits until any burn in progress, together with its quiet period, has finished.

Top module: `fuse_shadow_bank`

## Requirements
- R1: After reset the control register (byte address 0x000) reads 0, every shadow word reads 0, and the fuse read strobe is low.
- R2: Shadow word i sits at byte address 0x400 + 16*i. A bus read presents its data on the read-data output with the valid flag high in the next cycle. A bus write to an unlocked word while the bank is idle and error-free replaces that word.
- R3: A read of a read-locked shadow word returns 0xBADABADA and sets the error flag, which is bit 9 of the control register.
- R4: A write to a write-locked shadow word sets the error flag and leaves the word unchanged.
- R5: A write to any shadow word during a reload sets the error flag and leaves the word as the reload makes it. The reload itself runs to completion.
- R6: While the error flag is set, shadow reads return 0, shadow writes and reload requests are ignored, and control reads still work. Writing a 1 in bit 9 to the clear alias at byte address 0x008 clears the flag.
- R7: Writing a 1 in bit 10 to the set alias at byte address 0x004 starts a reload. From the next cycle until the reload ends, the control register shows bit 8 (busy) and bit 10 (reload) set. Both bits then clear without software action.
- R8: The first fuse read of a reload does not begin while the burn-active input is high.
- R9: For each word, in ascending order from 0, the read strobe is high for STROBE_READ cycles with the fuse address equal to the word index. Then come RELAX cycles with the strobe low, then one capture cycle. After the reload every shadow word equals its fuse word.
- R10: The lock vectors are sampled only when a reload is accepted. Changes to the lock inputs at any other time have no effect.
- R11: The window holds NUM_WORDS words (128 by default, 64 allowed). A read at or beyond the first address past the last word returns 0 and raises no error.
- R12: Reads of unmapped addresses and of addresses in the window that are not multiples of 16 return 0 without error. A write to the control register at 0x000 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, one cycle after the request |
| rdValid | output | 1 | busRdata holds a read result |
| fuseRdEn | output | 1 | Fuse array read strobe |
| fuseAddr | output | IDX_W | Fuse word being read |
| fuseRdata | input | DATA_W | Word returned by the fuse array |
| rdLockIn | input | NUM_WORDS | Per-word read-lock status |
| wrLockIn | input | NUM_WORDS | Per-word write-lock status |
| burnActive | input | 1 | A burn or its quiet period is in progress |

## Verification
If the sequencer's phase counter or word index goes wrong, it shows within one word period (STROBE_READ+RELAX+1 cycles) as a strobe at the wrong time or a wrong fuse address, and it shows again at the end of the reload as a wrong shadow value. A wrong lock snapshot or a sticky flag that does not stick only shows on the next read of the affected word or of the control register, so the bench reads those words and the control register right after each violation. Because the read data is registered, a wrong select or a wrong shadow slot appears in the cycle after the request.

// File: rtl/fuse_shadow_pkg.sv
package fuse_shadow_pkg;

  localparam int unsigned BusyBit   = 8;
  localparam int unsigned ErrBit    = 9;
  localparam int unsigned ReloadBit = 10;
  localparam logic [31:0] PoisonWord = 32'hBADA_BADA;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_SHADOW,
    RD_POISON,
    RD_STATUS
  } rdSel_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_STROBE,
    SQ_RELAX,
    SQ_LOAD
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   fuseLoad;
    logic   busWr;
    logic   rdCapture;
    rdSel_e rdSel;
  } dpCmd_t;

endpackage

// File: rtl/fuse_shadow_ctrl.sv
module fuse_shadow_ctrl
  import fuse_shadow_pkg::*;
#(
  parameter int NUM_WORDS   = 128,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int STROBE_READ = 4,
  parameter int RELAX       = 2,
  parameter int WIN_BASE    = 'h400,
  parameter int STRIDE_LOG2 = 4,
  localparam int IDX_W      = $clog2(NUM_WORDS),
  localparam int CNT_MAX    = (STROBE_READ > RELAX) ? STROBE_READ : RELAX,
  localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrReloadFlag,
  input  logic              wrErrClrFlag,
  input  logic [NUM_WORDS-1:0] rdLockIn,
  input  logic [NUM_WORDS-1:0] wrLockIn,
  input  logic              burnActive,
  output dpCmd_t            cmd,
  output logic [IDX_W-1:0]  busIdx,
  output logic [IDX_W-1:0]  loadIdx,
  output logic              fuseRdEn,
  output logic              busyBit,
  output logic              errBit,
  output logic [DATA_W-1:0] statusWord
);

  localparam logic [ADDR_W-1:0] CtrlAddr = '0;
  localparam logic [ADDR_W-1:0] SetAddr  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ClrAddr  = ADDR_W'(8);
  localparam logic [ADDR_W:0]   WinLo    = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0]   WinHi    = (ADDR_W+1)'(WIN_BASE + (NUM_WORDS << STRIDE_LOG2));
  localparam logic [STRIDE_LOG2-1:0] AlignZero = '0;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] word;
  logic [NUM_WORDS-1:0] rdLockQ;
  logic [NUM_WORDS-1:0] wrLockQ;
  logic             errQ;

  logic             rdReq, wrReq, inWin, startReq, errSet, errClr;
  logic [ADDR_W-1:0] offs;

  assign rdReq = busValid && !busWrite;
  assign wrReq = busValid && busWrite;
  assign offs  = busAddr - ADDR_W'(WIN_BASE);
  assign inWin = ({1'b0, busAddr} >= WinLo) && ({1'b0, busAddr} < WinHi)
                 && (busAddr[STRIDE_LOG2-1:0] == AlignZero);
  assign busIdx = IDX_W'(offs >> STRIDE_LOG2);

  assign busyBit  = (state != SQ_IDLE);
  assign errBit   = errQ;
  assign fuseRdEn = (state == SQ_STROBE);
  assign loadIdx  = word;

  assign startReq = wrReq && (busAddr == SetAddr) && wrReloadFlag && !errQ && !busyBit;
  assign errClr   = wrReq && (busAddr == ClrAddr) && wrErrClrFlag;

  always_comb begin
    cmd           = '0;
    cmd.rdSel     = RD_ZERO;
    cmd.rdCapture = rdReq;
    cmd.fuseLoad  = (state == SQ_LOAD);
    errSet        = 1'b0;
    if (rdReq) begin
      if (busAddr == CtrlAddr) begin
        cmd.rdSel = RD_STATUS;
      end else if (inWin && !errQ) begin
        if (rdLockQ[busIdx]) begin
          cmd.rdSel = RD_POISON;
          errSet    = 1'b1;
        end else begin
          cmd.rdSel = RD_SHADOW;
        end
      end
    end
    if (wrReq && inWin && !errQ) begin
      if (busyBit || wrLockQ[busIdx]) errSet    = 1'b1;
      else                            cmd.busWr = 1'b1;
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[BusyBit]   = busyBit;
    statusWord[ErrBit]    = errQ;
    statusWord[ReloadBit] = busyBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       errQ <= 1'b0;
    else if (errSet) errQ <= 1'b1;
    else if (errClr) errQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      word    <= '0;
      rdLockQ <= '0;
      wrLockQ <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (startReq) begin
          state   <= SQ_WAIT;
          rdLockQ <= rdLockIn;
          wrLockQ <= wrLockIn;
        end
        SQ_WAIT: if (!burnActive) begin
          state <= SQ_STROBE;
          cnt   <= '0;
          word  <= '0;
        end
        SQ_STROBE: if (cnt == CNT_W'(STROBE_READ - 1)) begin
          cnt   <= '0;
          state <= SQ_RELAX;
        end else begin
          cnt <= cnt + 1'b1;
        end
        SQ_RELAX: if (cnt == CNT_W'(RELAX - 1)) begin
          cnt   <= '0;
          state <= SQ_LOAD;
        end else begin
          cnt <= cnt + 1'b1;
        end
        SQ_LOAD: if (word == IDX_W'(NUM_WORDS - 1)) begin
          state <= SQ_IDLE;
        end else begin
          word  <= word + 1'b1;
          state <= SQ_STROBE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fuse_shadow_dp.sv
module fuse_shadow_dp
  import fuse_shadow_pkg::*;
#(
  parameter int NUM_WORDS = 128,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] fuseRdata,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] busRdata,
  output logic              rdValid
);

  logic [DATA_W-1:0] shadowQ [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic loadHit, busHit;
    assign loadHit = cmd.fuseLoad && (loadIdx == IDX_W'(i));
    assign busHit  = cmd.busWr && (busIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)        shadowQ[i] <= '0;
      else if (loadHit) shadowQ[i] <= fuseRdata;
      else if (busHit)  shadowQ[i] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= cmd.rdCapture;
      if (cmd.rdCapture) begin
        unique case (cmd.rdSel)
          RD_SHADOW: busRdata <= shadowQ[busIdx];
          RD_POISON: busRdata <= DATA_W'(PoisonWord);
          RD_STATUS: busRdata <= statusWord;
          default:   busRdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import fuse_shadow_pkg::*;
#(
  parameter int NUM_WORDS   = 128,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int STROBE_READ = 4,
  parameter int RELAX       = 2,
  localparam int IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 rdValid,
  output logic                 fuseRdEn,
  output logic [IDX_W-1:0]     fuseAddr,
  input  logic [DATA_W-1:0]    fuseRdata,
  input  logic [NUM_WORDS-1:0] rdLockIn,
  input  logic [NUM_WORDS-1:0] wrLockIn,
  input  logic                 burnActive
);

  dpCmd_t            cmd;
  logic [IDX_W-1:0]  busIdx;
  logic [IDX_W-1:0]  loadIdx;
  logic              busyBit;
  logic              errBit;
  logic [DATA_W-1:0] statusWord;

  assign fuseAddr = loadIdx;

  fuse_shadow_ctrl #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STROBE_READ(STROBE_READ), .RELAX(RELAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .wrReloadFlag(busWdata[ReloadBit]), .wrErrClrFlag(busWdata[ErrBit]),
    .rdLockIn(rdLockIn), .wrLockIn(wrLockIn), .burnActive(burnActive),
    .cmd(cmd), .busIdx(busIdx), .loadIdx(loadIdx), .fuseRdEn(fuseRdEn),
    .busyBit(busyBit), .errBit(errBit), .statusWord(statusWord)
  );

  fuse_shadow_dp #(
    .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busIdx(busIdx), .loadIdx(loadIdx),
    .busWdata(busWdata), .fuseRdata(fuseRdata), .statusWord(statusWord),
    .busRdata(busRdata), .rdValid(rdValid)
  );

endmodule

// File: rtl/fuse_shadow_chk.sv
module fuse_shadow_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              clrFlag,
  input logic              rdValid,
  input logic              fuseRdEn,
  input logic [IDX_W-1:0]  fuseAddr,
  input logic              busyBit,
  input logic              errBit
);

  localparam logic [ADDR_W-1:0] ClrAddr = ADDR_W'(8);

  p_strobe_in_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    fuseRdEn |-> busyBit);

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fuseRdEn && $past(fuseRdEn)) |-> $stable(fuseAddr));

  p_wait_before_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyBit) |-> !fuseRdEn);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errBit && !(busValid && busWrite && busAddr == ClrAddr && clrFlag)) |=> errBit);

  p_no_reload_under_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errBit && !busyBit) |=> !busyBit);

  p_err_from_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBit) |-> $past(busValid));

endmodule

bind fuse_shadow_bank fuse_shadow_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .clrFlag(busWdata[9]), .rdValid(rdValid),
  .fuseRdEn(fuseRdEn), .fuseAddr(fuseAddr), .busyBit(busyBit), .errBit(errBit)
);

// File: tb/fuse_shadow_bank_bench.sv
module fuse_shadow_bank_bench;

  localparam int NW = 128;
  localparam int SR = 4;
  localparam int RX = 2;
  localparam logic [31:0] POISON = 32'hBADA_BADA;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          busValid = 1'b0, busWrite = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          rdValid, fuseRdEn;
  logic [6:0]    fuseAddr;
  logic [31:0]   fuseRdata;
  logic [NW-1:0] rdLockIn = '0, wrLockIn = '0;
  logic          burnActive = 1'b0;
  logic [31:0]   fuseArr [NW];

  assign fuseRdata = fuseArr[fuseAddr];

  fuse_shadow_bank u_fuse_shadow_bank (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rdValid(rdValid), .fuseRdEn(fuseRdEn), .fuseAddr(fuseAddr),
    .fuseRdata(fuseRdata), .rdLockIn(rdLockIn), .wrLockIn(wrLockIn),
    .burnActive(burnActive)
  );

  int errors = 0, checks = 0;
  string curReq = "R1";

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mShadow [NW];
  bit   mRdL [NW];
  bit   mWrL [NW];
  bit   mErr;
  int   mPhase, mCnt, mWord;
  bit   expRdValid;
  logic [31:0] expRdata;

  task automatic modelStep();
    bit busyOld = (mPhase != 0);
    bit errOld  = mErr;
    int a = int'(busAddr);
    bit inW = (a >= 1024) && (a < 1024 + 16*NW) && (a % 16 == 0);
    int w = inW ? (a - 1024) / 16 : 0;
    bit start = 0;
    expRdValid = 0;
    if (busValid && !busWrite) begin
      expRdValid = 1;
      expRdata = 0;
      if (a == 0) expRdata = (busyOld ? 32'h500 : 32'h0) | (errOld ? 32'h200 : 32'h0);
      else if (inW && !errOld) begin
        if (mRdL[w]) begin expRdata = POISON; mErr = 1; end
        else expRdata = mShadow[w];
      end
    end
    if (busValid && busWrite) begin
      if (a == 4 && busWdata[10] && !errOld && !busyOld) start = 1;
      if (a == 8 && busWdata[9]) mErr = 0;
      if (inW && !errOld) begin
        if (busyOld || mWrL[w]) mErr = 1;
        else mShadow[w] = busWdata;
      end
    end
    case (mPhase)
      0: if (start) begin
           mPhase = 1;
           for (int i = 0; i < NW; i++) begin mRdL[i] = rdLockIn[i]; mWrL[i] = wrLockIn[i]; end
         end
      1: if (!burnActive) begin mPhase = 2; mCnt = 0; mWord = 0; end
      2: if (mCnt == SR-1) begin mCnt = 0; mPhase = 3; end else mCnt++;
      3: if (mCnt == RX-1) begin mCnt = 0; mPhase = 4; end else mCnt++;
      4: begin
           mShadow[mWord] = fuseArr[mWord];
           if (mWord == NW-1) mPhase = 0;
           else begin mWord++; mPhase = 2; end
         end
      default: mPhase = 0;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NW; i++) begin mShadow[i] = 0; mRdL[i] = 0; mWrL[i] = 0; end
      mErr = 0; mPhase = 0; mCnt = 0; mWord = 0; expRdValid = 0; expRdata = 0;
    end else modelStep();
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(rdValid === expRdValid, curReq, 32'(rdValid), 32'(expRdValid));
      if (expRdValid) check(busRdata === expRdata, curReq, busRdata, expRdata);
      check(fuseRdEn === (mPhase == 2), curReq, 32'(fuseRdEn), 32'(mPhase == 2));
      if (mPhase == 2) check(fuseAddr === 7'(mWord), curReq, 32'(fuseAddr), 32'(mWord));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic rd(input logic [11:0] addr, output logic [31:0] data);
    busValid = 1; busWrite = 0; busAddr = addr;
    @(negedge clk);
    busValid = 0;
    data = busRdata;
  endtask

  task automatic wr(input logic [11:0] addr, input logic [31:0] data);
    busValid = 1; busWrite = 1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rdExpect(input logic [11:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(addr, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int n = 0; n < 2000; n++) begin
      rd(12'h000, d);
      if (d[8] == 1'b0) break;
    end
  endtask

  task automatic runTests();
    logic [31:0] d;
    for (int i = 0; i < NW; i++) fuseArr[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    curReq = "R1";
    rdExpect(12'h000, 32'h0, "R1");
    rdExpect(12'h400, 32'h0, "R1");
    check(fuseRdEn === 1'b0, "R1", 32'(fuseRdEn), 0);

    curReq = "R2";
    wr(12'h400, 32'h1111_2222);
    wr(12'h450, 32'hDEAD_0005);
    wr(12'hBF0, 32'hCAFE_007F);
    rdExpect(12'h400, 32'h1111_2222, "R2");
    rdExpect(12'h450, 32'hDEAD_0005, "R2");
    rdExpect(12'hBF0, 32'hCAFE_007F, "R2");

    curReq = "R12";
    wr(12'h000, 32'hFFFF_FFFF);
    rdExpect(12'h000, 32'h0, "R12");
    rdExpect(12'h3F0, 32'h0, "R12");
    rdExpect(12'h404, 32'h0, "R12");
    curReq = "R11";
    rdExpect(12'hC00, 32'h0, "R11");
    rdExpect(12'h000, 32'h0, "R11");

    curReq = "R8";
    rdLockIn[3] = 1; wrLockIn[7] = 1; burnActive = 1;
    wr(12'h004, 32'h400);
    rdLockIn[3] = 0; rdLockIn[9] = 1; wrLockIn[7] = 0;   // R10: ignored until next reload
    rdExpect(12'h000, 32'h500, "R7");
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check(fuseRdEn === 1'b0, "R8", 32'(fuseRdEn), 0);
    end
    burnActive = 0;
    curReq = "R9";
    repeat (30) @(negedge clk);
    rdExpect(12'h000, 32'h500, "R7");
    waitIdle();
    rdExpect(12'h000, 32'h0, "R7");
    for (int i = 0; i < NW; i++)
      if (i != 3) rdExpect(12'(1024 + 16*i), fuseArr[i], "R9");

    curReq = "R3";
    rdExpect(12'h430, POISON, "R3");
    rdExpect(12'h000, 32'h200, "R3");
    curReq = "R6";
    rdExpect(12'h440, 32'h0, "R6");
    wr(12'h440, 32'h1234_5678);
    wr(12'h004, 32'h400);
    @(negedge clk);
    rdExpect(12'h000, 32'h200, "R6");
    wr(12'h008, 32'h200);
    rdExpect(12'h000, 32'h0, "R6");
    rdExpect(12'h440, fuseArr[4], "R6");

    curReq = "R10";
    rdExpect(12'h490, fuseArr[9], "R10");
    rdExpect(12'h000, 32'h0, "R10");

    curReq = "R4";
    wr(12'h470, 32'h5555_AAAA);
    rdExpect(12'h000, 32'h200, "R4");
    wr(12'h008, 32'h200);
    rdExpect(12'h470, fuseArr[7], "R4");

    curReq = "R5";
    for (int i = 0; i < NW; i++) fuseArr[i] = ~(32'(i) * 32'h0101_0101);
    wr(12'h004, 32'h400);
    repeat (20) @(negedge clk);
    wr(12'h400, 32'h7777_7777);
    rdExpect(12'h000, 32'h700, "R5");
    waitIdle();
    rdExpect(12'h000, 32'h200, "R5");
    wr(12'h008, 32'h200);
    rdExpect(12'h400, fuseArr[0], "R5");
    curReq = "R10";
    rdExpect(12'h430, fuseArr[3], "R10");
    rdExpect(12'h490, POISON, "R10");
    wr(12'h008, 32'h200);
    rdExpect(12'h000, 32'h0, "R10");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule